// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two direction predictors in parallel. The local side keeps a short outcome history for each branch slot, selected by the low bits of the branch address, and uses that history to pick a two-bit counter. The global side keeps one shift register of the most recent outcomes of all branches and uses it to pick a counter in a second table. A third table of two-bit chooser counters decides which of the two results to trust. That table is indexed by the global history, so the choice follows the path that led to the branch.

A lookup is combinational. The fetch stage drives the branch address and reads back the final prediction, both sub-predictions, the chooser's selection and the two history values that were used. The pipeline keeps the histories and the two sub-predictions with the branch. When the branch resolves, they are returned on the update port together with the real outcome. On each update the block trains both direction counters and, when the two sub-predictions differed, the chooser entry. It then shifts the outcome into the branch's local history and into the global history. Target prediction and history repair after a misprediction are handled elsewhere.

Top module: `tourney_bp`

## Requirements
- R1: After reset, every local history entry and the global history are 0, and every direction counter holds 1 (weakly not taken). Every chooser counter holds 1, so for any address all prediction outputs read 0.
- R2: Direction counters are two-bit saturating. A value of 2 or 3 predicts taken. A taken outcome adds one, up to 3, and a not-taken outcome subtracts one, down to 0. From a saturated value, two opposite outcomes in a row are needed before the prediction flips.
- R3: `pred_taken_o` equals `global_pred_o` when `use_global_o` is 1 and equals `local_pred_o` when it is 0. When the two sub-predictions agree, it equals both.
- R4: A chooser counter with value 2 or 3 selects the global side, and a value of 0 or 1 selects the local side. It changes only on an update whose two saved sub-predictions differ. It then moves one step, saturating, toward the side that matched the outcome: up when the global side was right, down when the local side was right.
- R5: `br_addr_i` selects the local history entry reported on `lhist_o`. An update shifts the outcome into bit 0 of the entry selected by `upd_addr_i` and leaves the other entries unchanged.
- R6: Every update shifts the outcome into bit 0 of the global history, which is reported on `ghist_o`. The oldest bit is dropped.
- R7: On update, the local counter at `upd_lhist_i` and the global counter at `upd_ghist_i` are trained. The chooser entry trained is the one at `upd_ghist_i`. A lookup reads the local counter at `lhist_o` and both the global counter and the chooser at `ghist_o`.
- R8: While `upd_valid_i` is 0, no state changes, so the outputs for a held address stay constant.
- R9: Chooser entries are selected per global history value. Training the entry for one history value does not change the selection seen under another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_addr_i | input | LHT_IDX_W | Low address bits of the branch being looked up |
| pred_taken_o | output | 1 | Final direction prediction |
| local_pred_o | output | 1 | Local-side prediction |
| global_pred_o | output | 1 | Global-side prediction |
| use_global_o | output | 1 | Chooser selection, 1 = global side |
| lhist_o | output | LHIST_W | Local history used for this lookup |
| ghist_o | output | GHIST_W | Global history used for this lookup |
| upd_valid_i | input | 1 | Update strobe |
| upd_addr_i | input | LHT_IDX_W | Address bits of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_lhist_i | input | LHIST_W | Local history saved at lookup |
| upd_ghist_i | input | GHIST_W | Global history saved at lookup |
| upd_local_pred_i | input | 1 | Local prediction saved at lookup |
| upd_global_pred_i | input | 1 | Global prediction saved at lookup |

## Verification
The assertions assume that the update fields were captured from this block's own lookup outputs. The chooser check in particular assumes that a global history of zero presented on the update port means chooser entry zero. The lookup address is assumed to come from outside and to be free to change in any cycle. Because of this, the properties about held outputs and local-history shifts apply only in cycles where the address did not move. The stimulus table replays lookups whose outputs are fed straight back as the saved fields. The directed tests write saved fields by hand to reach single counters. After each such write they restore the global history with not-taken updates aimed at unused counters, so the entry under test is read back through the normal lookup path.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'd1;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == 2'd3) ? c : c + 2'd1;
    else    r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_taken(input ctr2_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int    IDX_W   = 8,
  parameter ctr2_t RST_VAL = CTR_WEAK_NT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr2_t            rd_val_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem_q [DEPTH];

  assign rd_val_o = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= ctr_step(mem_q[wr_idx_i], wr_up_i);
    end
  end
endmodule

// File: rtl/tbp_local_hist.sv
module tbp_local_hist #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_bit_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  assign rd_hist_o = hist_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en_i) begin
      hist_q[wr_idx_i] <= {hist_q[wr_idx_i][HIST_W-2:0], wr_bit_i};
    end
  end
endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  assign hist_o = hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (shift_en_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int LHT_IDX_W = 6,
  parameter int LHIST_W   = 10,
  parameter int GHIST_W   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LHT_IDX_W-1:0] br_addr_i,
  output logic                 pred_taken_o,
  output logic                 local_pred_o,
  output logic                 global_pred_o,
  output logic                 use_global_o,
  output logic [LHIST_W-1:0]   lhist_o,
  output logic [GHIST_W-1:0]   ghist_o,
  input  logic                 upd_valid_i,
  input  logic [LHT_IDX_W-1:0] upd_addr_i,
  input  logic                 upd_taken_i,
  input  logic [LHIST_W-1:0]   upd_lhist_i,
  input  logic [GHIST_W-1:0]   upd_ghist_i,
  input  logic                 upd_local_pred_i,
  input  logic                 upd_global_pred_i
);
  ctr2_t lctr_val, gctr_val, chs_val;
  logic  chs_wr_en, chs_wr_up;

  // local side: per-slot history, then pattern counters
  tbp_local_hist #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk_i, .rst_ni,
    .rd_idx_i (br_addr_i),
    .rd_hist_o(lhist_o),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (upd_addr_i),
    .wr_bit_i (upd_taken_i)
  );

  tbp_ctr_table #(.IDX_W(LHIST_W), .RST_VAL(CTR_WEAK_NT)) u_lctr (
    .clk_i, .rst_ni,
    .rd_idx_i(lhist_o),
    .rd_val_o(lctr_val),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(upd_lhist_i),
    .wr_up_i (upd_taken_i)
  );

  // global side
  tbp_ghr #(.HIST_W(GHIST_W)) u_ghr (
    .clk_i, .rst_ni,
    .shift_en_i(upd_valid_i),
    .bit_i     (upd_taken_i),
    .hist_o    (ghist_o)
  );

  tbp_ctr_table #(.IDX_W(GHIST_W), .RST_VAL(CTR_WEAK_NT)) u_gctr (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist_o),
    .rd_val_o(gctr_val),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(upd_ghist_i),
    .wr_up_i (upd_taken_i)
  );

  // chooser: trained on disagreement only, toward the side that was right
  assign chs_wr_en = upd_valid_i && (upd_local_pred_i != upd_global_pred_i);
  assign chs_wr_up = (upd_global_pred_i == upd_taken_i);

  tbp_ctr_table #(.IDX_W(GHIST_W), .RST_VAL(CTR_WEAK_NT)) u_chs (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist_o),
    .rd_val_o(chs_val),
    .wr_en_i (chs_wr_en),
    .wr_idx_i(upd_ghist_i),
    .wr_up_i (chs_wr_up)
  );

  always_comb begin
    local_pred_o  = ctr_taken(lctr_val);
    global_pred_o = ctr_taken(gctr_val);
    use_global_o  = ctr_taken(chs_val);
    pred_taken_o  = use_global_o ? global_pred_o : local_pred_o;
  end
endmodule

// File: rtl/tbp_chk.sv
module tbp_chk #(
  parameter int LHT_IDX_W = 6,
  parameter int LHIST_W   = 10,
  parameter int GHIST_W   = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [LHT_IDX_W-1:0] br_addr_i,
  input logic                 pred_taken_o,
  input logic                 local_pred_o,
  input logic                 global_pred_o,
  input logic                 use_global_o,
  input logic [LHIST_W-1:0]   lhist_o,
  input logic [GHIST_W-1:0]   ghist_o,
  input logic                 upd_valid_i,
  input logic [LHT_IDX_W-1:0] upd_addr_i,
  input logic                 upd_taken_i,
  input logic [GHIST_W-1:0]   upd_ghist_i,
  input logic                 upd_local_pred_i,
  input logic                 upd_global_pred_i
);
  // R6
  ghist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghist_o == {$past(ghist_o[GHIST_W-2:0]), $past(upd_taken_i)});

  // R8
  ghist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghist_o));

  // R8
  pred_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> (!$stable(br_addr_i) ||
      $stable({pred_taken_o, local_pred_o, global_pred_o, use_global_o, lhist_o})));

  // R3
  agree_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (local_pred_o == global_pred_o) |-> (pred_taken_o == local_pred_o));

  // R5
  lhist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_addr_i == br_addr_i) |=> (!$stable(br_addr_i) ||
      lhist_o == {$past(lhist_o[LHIST_W-2:0]), $past(upd_taken_i)}));

  // R4
  chooser_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_local_pred_i == upd_global_pred_i && !upd_taken_i &&
     ghist_o == '0 && upd_ghist_i == '0) |=> $stable(use_global_o));
endmodule

bind tourney_bp tbp_chk #(
  .LHT_IDX_W(LHT_IDX_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)
) u_chk (
  .clk_i, .rst_ni, .br_addr_i, .pred_taken_o, .local_pred_o, .global_pred_o,
  .use_global_o, .lhist_o, .ghist_o, .upd_valid_i, .upd_addr_i, .upd_taken_i,
  .upd_ghist_i, .upd_local_pred_i, .upd_global_pred_i
);

// File: tb/sim_tourney_bp.sv
module sim_tourney_bp;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int LW = 10;
  localparam int GW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] br_addr_i = '0;
  logic          pred_taken_o, local_pred_o, global_pred_o, use_global_o;
  logic [LW-1:0] lhist_o;
  logic [GW-1:0] ghist_o;
  logic          upd_valid_i = 1'b0;
  logic [AW-1:0] upd_addr_i = '0;
  logic          upd_taken_i = 1'b0;
  logic [LW-1:0] upd_lhist_i = '0;
  logic [GW-1:0] upd_ghist_i = '0;
  logic          upd_local_pred_i = 1'b0;
  logic          upd_global_pred_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tourney_bp #(.LHT_IDX_W(AW), .LHIST_W(LW), .GHIST_W(GW)) u0 (.*);

  // {local, global, use_global, final, lhist, ghist}, address 5, outcome always taken
  localparam logic [21:0] VEC [12] = '{
    {4'b0000, 10'd0,    8'd0},
    {4'b0000, 10'd1,    8'd1},
    {4'b0000, 10'd3,    8'd3},
    {4'b0000, 10'd7,    8'd7},
    {4'b0000, 10'd15,   8'd15},
    {4'b0000, 10'd31,   8'd31},
    {4'b0000, 10'd63,   8'd63},
    {4'b0000, 10'd127,  8'd127},
    {4'b0000, 10'd255,  8'd255},
    {4'b0100, 10'd511,  8'd255},
    {4'b0111, 10'd1023, 8'd255},
    {4'b1111, 10'd1023, 8'd255}
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic look(input logic [AW-1:0] a);
    @(negedge clk_i);
    br_addr_i = a;
    #1;
  endtask

  task automatic upd(input logic [AW-1:0] a, input logic [LW-1:0] lh,
                     input logic [GW-1:0] gh, input logic lp, input logic gp,
                     input logic t);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_addr_i = a; upd_taken_i = t;
    upd_lhist_i = lh; upd_ghist_i = gh;
    upd_local_pred_i = lp; upd_global_pred_i = gp;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  // clear global history with not-taken updates aimed at unused counters
  task automatic clear_ghist();
    for (int i = 0; i < GW; i++) upd(6'd63, 10'd1000, 8'd200, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic train(input logic [LW-1:0] lh, input logic [GW-1:0] gh,
                       input logic lp, input logic gp, input logic t);
    upd(6'd63, lh, gh, lp, gp, t);
    if (t) clear_ghist();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    look(6'd5);
    // R1
    chk("R1 final", pred_taken_o, 0);
    chk("R1 local", local_pred_o, 0);
    chk("R1 global", global_pred_o, 0);
    chk("R1 chooser", use_global_o, 0);
    chk("R1 lhist", lhist_o, 0);
    chk("R1 ghist", ghist_o, 0);

    // R3 R4 R5 R6 R7: lookups fed straight back as saved fields
    for (int s = 0; s < 12; s++) begin
      logic lp, gp, ug, fp;
      logic [LW-1:0] lh;
      logic [GW-1:0] gh;
      look(6'd5);
      {lp, gp, ug, fp, lh, gh} = VEC[s];
      chk($sformatf("R7 local step %0d", s), local_pred_o, lp);
      chk($sformatf("R7 global step %0d", s), global_pred_o, gp);
      chk($sformatf("R4 chooser step %0d", s), use_global_o, ug);
      chk($sformatf("R3 final step %0d", s), pred_taken_o, fp);
      chk($sformatf("R5 lhist step %0d", s), lhist_o, lh);
      chk($sformatf("R6 ghist step %0d", s), ghist_o, gh);
      upd(6'd5, lhist_o, ghist_o, local_pred_o, global_pred_o, 1'b1);
    end

    // R2: counters at index 0 of both tables
    do_reset();
    train(10'd0, 8'd0, 1'b0, 1'b0, 1'b1);
    look(6'd5);
    chk("R2 weak to taken local", local_pred_o, 1);
    chk("R2 weak to taken global", global_pred_o, 1);
    train(10'd0, 8'd0, 1'b0, 1'b0, 1'b1);
    train(10'd0, 8'd0, 1'b0, 1'b0, 1'b1);
    train(10'd0, 8'd0, 1'b0, 1'b0, 1'b0);
    look(6'd5);
    chk("R2 one miss from saturated local", local_pred_o, 1);
    chk("R2 one miss from saturated global", global_pred_o, 1);
    train(10'd0, 8'd0, 1'b0, 1'b0, 1'b0);
    look(6'd5);
    chk("R2 second miss flips local", local_pred_o, 0);
    chk("R2 second miss flips global", global_pred_o, 0);

    // R4 R9: chooser entry 0
    do_reset();
    train(10'd900, 8'd0, 1'b0, 1'b1, 1'b1);
    look(6'd5);
    chk("R4 global right selects global", use_global_o, 1);
    chk("R3 final follows global", pred_taken_o, 1);
    upd(6'd63, 10'd1000, 8'd150, 1'b0, 1'b0, 1'b1);
    look(6'd5);
    chk("R9 other path keeps local", use_global_o, 0);
    clear_ghist();
    look(6'd5);
    chk("R9 path 0 still global", use_global_o, 1);
    train(10'd900, 8'd0, 1'b1, 1'b1, 1'b0);
    look(6'd5);
    chk("R4 agreement leaves chooser", use_global_o, 1);
    train(10'd900, 8'd0, 1'b0, 1'b1, 1'b0);
    look(6'd5);
    chk("R4 local right selects local", use_global_o, 0);
    train(10'd900, 8'd0, 1'b0, 1'b1, 1'b0);
    train(10'd900, 8'd0, 1'b0, 1'b1, 1'b1);
    look(6'd5);
    chk("R4 saturated low needs two", use_global_o, 0);
    train(10'd900, 8'd0, 1'b0, 1'b1, 1'b1);
    look(6'd5);
    chk("R4 back to global", use_global_o, 1);

    // R5 R8: per-slot local history, hold without update
    do_reset();
    upd(6'd6, 10'd1000, 8'd200, 1'b0, 1'b0, 1'b1);
    look(6'd6);
    chk("R5 updated slot", lhist_o, 1);
    look(6'd5);
    chk("R5 other slot untouched", lhist_o, 0);
    repeat (3) @(negedge clk_i);
    look(6'd6);
    chk("R8 lhist held", lhist_o, 1);
    chk("R8 ghist held", ghist_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule